// File: doc/BRIEF.md
# Orbiting Square Glyph Controller

This block animates a small square glyph that travels around a row of four seven-segment digits. The glyph is drawn either in the top half of a digit (a box made of segments a, b, f and g) or in its bottom half (a box made of segments c, d, e and g). It runs along the top of the row from left to right, then back along the bottom from right to left. The result is a closed loop of eight positions.

A free-running base divider issues one tick every `BASE_DIV` clocks. With the default of 500,000 clocks and a 50 MHz clock, this is one tick every 10 ms. A rate stage counts base ticks and issues a one-cycle step strobe after 2, 4, 8 or 16 of them, as set by a 2-bit speed input. Each strobe moves a 3-bit position counter one place, either forwards or backwards, unless motion is frozen. A decoder turns the position into four active-low segment buses, one per digit. The dividers are parameters, so a short interval can be used in simulation.

Top module: `square_orbit_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, the position becomes 0 and both dividers are cleared. After that edge, the first step occurs at the edge that ends clock number 2·`BASE_DIV` counted from the first clock without reset, provided the speed select stays at 00.
- R2: Segment buses are active-low, with bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g. The top box drives 7'b0011100 and the bottom box drives 7'b0100011. An unlit digit drives 7'b1111111.
- R3: With `dir` = 1, each step increments the position, and 7 wraps to 0.
- R4: With `dir` = 0, each step decrements the position, and 0 wraps to 7.
- R5: While `pause` = 1, the position and the display hold their values. The dividers keep counting during a pause.
- R6: Outside reset, exactly one of the four buses is not all ones.
- R7: Steps are single-cycle strobes that occur only on a base tick. The dwell per position is 2·`BASE_DIV`, 4·`BASE_DIV`, 8·`BASE_DIV` or 16·`BASE_DIV` clocks for speed 00, 01, 10 and 11 respectively.
- R8: A change of the speed select restarts the base-tick count. No step is issued in the cycle in which the change is first seen, and the next step needs a full count at the new rate.
- R9: Positions 0 to 3 show the top box on `seg_d0` (leftmost digit) through `seg_d3` (rightmost digit). Positions 4 to 7 show the bottom box on `seg_d3` through `seg_d0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pause | input | 1 | Freezes the glyph when high |
| dir | input | 1 | 1 = forward (clockwise), 0 = backward |
| speed | input | RATE_SEL_W | Dwell select, 00 fastest |
| seg_d0 | output | 7 | Leftmost digit segments, active-low |
| seg_d1 | output | 7 | Second digit segments |
| seg_d2 | output | 7 | Third digit segments |
| seg_d3 | output | 7 | Rightmost digit segments |

## Verification
The glyph is first driven forwards through more than one full loop. This separates the position-to-digit mapping of the top and bottom halves and exposes any error in the forward wrap. It is then driven backwards across the 0-to-7 wrap, which shows whether the direction input really reverses the count rather than simply restarting it. The dwell between display changes is measured at every speed code to tell the four rates apart. Mid-interval speed changes and a long pause check that the step count restarts and that a frozen glyph stays frozen while the dividers run on.

// File: rtl/sqo_pkg.sv
package sqo_pkg;
   localparam int SEG_W     = 7;
   localparam int DIGITS    = 4;
   localparam int POSITIONS = 2 * DIGITS;
   localparam int POS_W     = $clog2(POSITIONS);

   typedef logic [SEG_W-1:0] seg_t;
   typedef logic [POS_W-1:0] pos_t;

   // active-low, bit0 = a ... bit6 = g
   localparam seg_t SEG_BLANK = 7'b1111111;
   localparam seg_t SEG_UPPER = 7'b0011100;   // a b f g lit
   localparam seg_t SEG_LOWER = 7'b0100011;   // c d e g lit

   typedef enum logic {DIR_BACK = 1'b0, DIR_FWD = 1'b1} dir_e;
endpackage

// File: rtl/sqo_base_div.sv
module sqo_base_div #(
   parameter int unsigned DIV = 500000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("sqo_base_div: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign tick = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sqo_rate_strobe.sv
module sqo_rate_strobe #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             base_tick,
   input  logic [SEL_W-1:0] sel,
   output logic             step
);
   // limit = 2 << sel, largest is 2**(2**SEL_W); counter holds limit-1
   localparam int CNT_W = 2 ** SEL_W;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("sqo_rate_strobe: SEL_W must lie in 1..4");
   end

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic             changed;
   logic             at_last;

   always_comb begin
      last    = (CNT_W'(1) << (int'(sel) + 1)) - CNT_W'(1);
      changed = (sel != sel_q);
      at_last = (cnt == last);
      step    = base_tick & at_last & ~changed;
   end

   always_ff @(posedge clk) begin
      sel_q <= sel;
      if (rst)            cnt <= '0;
      else if (changed)   cnt <= '0;
      else if (base_tick) cnt <= at_last ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/sqo_pos_ctr.sv
module sqo_pos_ctr
   import sqo_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic step,
   input  logic hold,
   input  logic dir,
   output pos_t pos
);
   if (POSITIONS != (1 << POS_W)) begin : g_bad_ring
      $error("sqo_pos_ctr: ring length must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (rst)
         pos <= '0;
      else if (step && !hold)
         pos <= (dir_e'(dir) == DIR_FWD) ? pos + 1'b1 : pos - 1'b1;
   end
endmodule

// File: rtl/sqo_glyph_dec.sv
module sqo_glyph_dec
   import sqo_pkg::*;
(
   input  pos_t pos,
   output seg_t segs [DIGITS]
);
   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      localparam pos_t TOP_POS = pos_t'(d);
      localparam pos_t BOT_POS = pos_t'(POSITIONS - 1 - d);
      always_comb begin
         if (pos == TOP_POS)      segs[d] = SEG_UPPER;
         else if (pos == BOT_POS) segs[d] = SEG_LOWER;
         else                     segs[d] = SEG_BLANK;
      end
   end
endmodule

// File: rtl/square_orbit_ctrl.sv
module square_orbit_ctrl
   import sqo_pkg::*;
#(
   parameter int unsigned BASE_DIV   = 500000,
   parameter int          RATE_SEL_W = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  pause,
   input  logic                  dir,
   input  logic [RATE_SEL_W-1:0] speed,
   output logic [SEG_W-1:0]      seg_d0,
   output logic [SEG_W-1:0]      seg_d1,
   output logic [SEG_W-1:0]      seg_d2,
   output logic [SEG_W-1:0]      seg_d3
);
   if (DIGITS != 4) begin : g_bad_digits
      $error("square_orbit_ctrl: port list assumes four digits");
   end

   logic base_tick;
   logic step;
   pos_t pos;
   seg_t segs [DIGITS];

   sqo_base_div #(.DIV(BASE_DIV)) u_base (
      .clk  (clk),
      .rst  (rst),
      .tick (base_tick)
   );

   sqo_rate_strobe #(.SEL_W(RATE_SEL_W)) u_rate (
      .clk       (clk),
      .rst       (rst),
      .base_tick (base_tick),
      .sel       (speed),
      .step      (step)
   );

   sqo_pos_ctr u_pos (
      .clk  (clk),
      .rst  (rst),
      .step (step),
      .hold (pause),
      .dir  (dir),
      .pos  (pos)
   );

   sqo_glyph_dec u_dec (
      .pos  (pos),
      .segs (segs)
   );

   assign seg_d0 = segs[0];
   assign seg_d1 = segs[1];
   assign seg_d2 = segs[2];
   assign seg_d3 = segs[3];
endmodule

// File: rtl/sqo_orbit_chk.sv
module sqo_orbit_chk #(
   parameter int POS_W = 3,
   parameter int SEL_W = 2,
   parameter int SEG_W = 7
) (
   input logic             clk,
   input logic             rst,
   input logic             pause,
   input logic             dir,
   input logic [SEL_W-1:0] speed,
   input logic             base_tick,
   input logic             step,
   input logic [POS_W-1:0] pos,
   input logic [SEG_W-1:0] s0,
   input logic [SEG_W-1:0] s1,
   input logic [SEG_W-1:0] s2,
   input logic [SEG_W-1:0] s3
);
   AST_RESET_HOME: assert property (@(posedge clk) rst |=> (pos == '0)); // R1
   AST_FWD_STEP: assert property (@(posedge clk) disable iff (rst)
      (step && !pause && dir) |=> (pos == POS_W'($past(pos) + 1'b1))); // R3
   AST_BACK_STEP: assert property (@(posedge clk) disable iff (rst)
      (step && !pause && !dir) |=> (pos == POS_W'($past(pos) - 1'b1))); // R4
   AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
      pause |=> (pos == $past(pos))); // R5
   AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
      $countones({s0 != '1, s1 != '1, s2 != '1, s3 != '1}) == 1); // R6
   AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      step |-> base_tick); // R7
   AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
      step |=> !step); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !step |=> (pos == $past(pos))); // R7
   AST_RATE_RESTART: assert property (@(posedge clk) disable iff (rst)
      (speed != $past(speed)) |-> !step); // R8
endmodule

bind square_orbit_ctrl sqo_orbit_chk #(
   .POS_W (sqo_pkg::POS_W),
   .SEL_W (RATE_SEL_W),
   .SEG_W (sqo_pkg::SEG_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .pause     (pause),
   .dir       (dir),
   .speed     (speed),
   .base_tick (base_tick),
   .step      (step),
   .pos       (pos),
   .s0        (seg_d0),
   .s1        (seg_d1),
   .s2        (seg_d2),
   .s3        (seg_d3)
);

// File: tb/sim_square_orbit_ctrl.sv
`timescale 1ns/1ps
module sim_square_orbit_ctrl;
   localparam int BD = 3;
   localparam logic [6:0] UP = 7'b0011100;
   localparam logic [6:0] LO = 7'b0100011;
   localparam logic [6:0] BL = 7'b1111111;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pause = 1'b0;
   logic       dir = 1'b1;
   logic [1:0] speed = 2'b00;
   logic [6:0] seg_d0, seg_d1, seg_d2, seg_d3;

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   bit    model_ok = 1'b0;
   string phase = "R1";

   // behavioural reference state
   int m_base = 0, m_cnt = 0, m_pos = 0, m_spd = 0;

   always #2.5 clk = ~clk;

   square_orbit_ctrl #(.BASE_DIV(BD), .RATE_SEL_W(2)) u0 (
      .clk(clk), .rst(rst), .pause(pause), .dir(dir), .speed(speed),
      .seg_d0(seg_d0), .seg_d1(seg_d1), .seg_d2(seg_d2), .seg_d3(seg_d3)
   );

   function automatic logic [6:0] exp_seg(int p, int d);
      if (p < 4) return (p == d) ? UP : BL;
      return (7 - p == d) ? LO : BL;
   endfunction

   function automatic logic [27:0] exp_all(int p);
      return {exp_seg(p, 3), exp_seg(p, 2), exp_seg(p, 1), exp_seg(p, 0)};
   endfunction

   task automatic check(string req, logic [27:0] act, logic [27:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // reference model, advances on each rising edge
   always @(posedge clk) begin
      if (rst) begin
         m_base = 0; m_cnt = 0; m_pos = 0;
         model_ok = 1'b1;
      end else begin
         bit bt, chg, st;
         int lim;
         bt  = (m_base == BD - 1);
         m_base = bt ? 0 : m_base + 1;
         chg = (int'(speed) != m_spd);
         lim = 2 << speed;
         st  = 1'b0;
         if (chg) m_cnt = 0;
         else if (bt) begin
            st = (m_cnt == lim - 1);
            m_cnt = st ? 0 : m_cnt + 1;
         end
         if (st && !pause) m_pos = dir ? (m_pos + 1) % 8 : (m_pos + 7) % 8;
      end
      m_spd = int'(speed);
   end

   // per-cycle comparison against the model, labelled by the running phase
   always @(negedge clk) begin
      cyc++;
      if (model_ok && !done)
         check(phase, {seg_d3, seg_d2, seg_d1, seg_d0}, exp_all(m_pos));
      if (model_ok && !rst && !done) begin
         n_chk++;
         if ($countones({seg_d0 != BL, seg_d1 != BL, seg_d2 != BL, seg_d3 != BL}) != 1) begin
            n_bad++;
            $display("FAIL R6: lit digits %b expected exactly one",
                     {seg_d3 != BL, seg_d2 != BL, seg_d1 != BL, seg_d0 != BL});
         end
      end
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic measure_dwell(int s);
      logic [27:0] prev;
      int n;
      phase = "R7";
      speed = 2'(s);
      prev = {seg_d3, seg_d2, seg_d1, seg_d0};
      do @(negedge clk); while ({seg_d3, seg_d2, seg_d1, seg_d0} == prev);
      prev = {seg_d3, seg_d2, seg_d1, seg_d0};
      n = 0;
      do begin @(negedge clk); n++; end while ({seg_d3, seg_d2, seg_d1, seg_d0} == prev);
      check("R7", 28'(n), 28'((2 << s) * BD));
   endtask

   initial begin
      logic [27:0] snap;
      repeat (3) @(negedge clk);
      // R1 and R2: home position after reset, exact top-box code on leftmost digit
      check("R1", {seg_d3, seg_d2, seg_d1, seg_d0}, {BL, BL, BL, UP});
      check("R2", {21'h0, seg_d0}, {21'h0, 7'b0011100});
      rst = 1'b0;
      // R1: first step lands after 2*BD clocks at speed 00
      repeat (2 * BD - 1) @(negedge clk);
      check("R1", {seg_d3, seg_d2, seg_d1, seg_d0}, {BL, BL, BL, UP});
      @(negedge clk);
      check("R1", {seg_d3, seg_d2, seg_d1, seg_d0}, {BL, BL, UP, BL});
      phase = "R9";
      repeat (7 * 2 * BD) @(negedge clk);
      phase = "R3";
      repeat (12 * 2 * BD) @(negedge clk);
      dir = 1'b0;
      phase = "R4";
      repeat (20 * 2 * BD) @(negedge clk);
      // R5: long pause, display must not move
      phase = "R5";
      pause = 1'b1;
      @(negedge clk);
      snap = {seg_d3, seg_d2, seg_d1, seg_d0};
      repeat (100) @(negedge clk);
      check("R5", {seg_d3, seg_d2, seg_d1, seg_d0}, snap);
      pause = 1'b0;
      dir = 1'b1;
      for (int s = 0; s < 4; s++) measure_dwell(s);
      // R8: speed changes in the middle of intervals
      phase = "R8";
      speed = 2'd3; repeat (20) @(negedge clk);
      speed = 2'd0; repeat (40) @(negedge clk);
      speed = 2'd2; repeat (5)  @(negedge clk);
      speed = 2'd1; repeat (60) @(negedge clk);
      dir = 1'b0;   repeat (40) @(negedge clk);
      // R1: reset in mid-run returns home
      phase = "R1";
      rst = 1'b1;
      @(negedge clk);
      check("R1", {seg_d3, seg_d2, seg_d1, seg_d0}, {BL, BL, BL, UP});
      rst = 1'b0;
      repeat (30) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule